// File: doc/BRIEF.md
# PLL Reconfiguration Sequencer

This block reprograms a multiplier-based PLL safely through the PLL's register port. It accepts a command over a valid/ready handshake. The command carries a multiplier control word that another block has already encoded. The sequencer first powers the PLL down and turns off every alternative clock path. While the PLL is down it loads the new multiplier and sets both the pre-divider and the post-divider to one. It then powers the PLL back up with its output still gated.

After power-up the block waits for a fixed number of timebase strobes and then samples the PLL lock flag. The strobes come from a free-running tick, so the wait is a fixed span of time. If the flag is set, the block enables the clock output and pulses `done`. If the flag is still clear, the block waits again. After the last permitted sample it pulses `fail` and leaves the output disabled. While the PLL is in bypass its output follows its input frequency. For that reason the sequencer clears bypass in its first write, so that the new multiplier takes effect.

Each register access leaves the block as a one-cycle strobe carrying an address and a 32-bit value. There is no read path. Every control value is therefore written as a complete word.

Top module: `pllseq_ctrl`

## Requirements
- R1: After reset `cmd_ready` is 1, and `busy`, `done`, `fail` and `wr_en` are all 0.
- R2: The clock edge that accepts a command (`cmd_valid` and `cmd_ready` both high) is followed by a cycle with a control write: `wr_en`=1, `wr_addr`=0, `wr_data`=0x00000001. The control word has power-down at bit 0, bypass at bit 1, direct-input at bit 2, direct-output at bit 3 and clock-output enable at bit 4, so this write sets power-down and clears the other four bits.
- R3: The two cycles after that write carry two more writes, in this order: the multiplier word at `wr_addr`=1 with the value taken with the command, then `wr_addr`=2 with 0x00302062, the value that sets both dividers to one.
- R4: The cycle after the divider write carries a control write of 0x00000000 (power-down cleared, output enable still cleared).
- R5: After the power-up write, and again after each failed sample, the lock input is sampled once exactly `WAIT_TICKS` timebase strobes later. Strobes that arrive outside a wait are not counted.
- R6: If the sample sees lock, the next cycle carries a control write of 0x00000010 (output enable set). `done` pulses for one cycle in the cycle after that write.
- R7: The block takes at most `MAX_SAMPLES` samples. If none of them sees lock, `fail` pulses for one cycle in the cycle after the last sample, and no write setting output enable is issued.
- R8: From acceptance until and including the `done` or `fail` cycle, `busy` is 1 and `cmd_ready` is 0. Any `cmd_valid` in that time is ignored and does not change the multiplier word written.
- R9: `done` and `fail` each last one cycle and are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Reconfiguration request |
| cmd_ready | output | 1 | High when idle and able to accept a request |
| cmd_mult | input | 32 | Encoded multiplier word for the request |
| tick | input | 1 | One-cycle strobe from the free-running timebase |
| lock_i | input | 1 | PLL lock flag (status bit 0) |
| wr_en | output | 1 | One-cycle register write strobe |
| wr_addr | output | 2 | Write address: 0 control, 1 multiplier, 2 dividers |
| wr_data | output | 32 | Write value |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse: PLL locked and output enabled |
| fail | output | 1 | One-cycle pulse: no lock within the permitted samples |

## Verification
The four setup writes are due in the four cycles that follow the accepting edge. The bench steps one falling edge at a time and compares the address and value in each of those cycles. The wait is measured in strobes rather than cycles. A monitor counts the strobes that fall strictly between the power-up write and the enable write, or the `fail` pulse. That count must equal `WAIT_TICKS` times the number of samples taken. The `done` pulse is expected exactly one cycle after the enable write, and `fail` one cycle after the last sample.

// File: rtl/pllseq_pkg.sv
package pllseq_pkg;
  localparam int ADDR_W = 2;
  localparam int DATA_W = 32;

  localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] A_MULT = 2'd1;
  localparam logic [ADDR_W-1:0] A_DIVS = 2'd2;

  localparam int B_PWRDN  = 0;
  localparam int B_BYPASS = 1;
  localparam int B_DIRIN  = 2;
  localparam int B_DIROUT = 3;
  localparam int B_OUTEN  = 4;

  localparam logic [DATA_W-1:0] DIVS_UNITY = 32'h0030_2062;

  typedef enum logic [3:0] {
    S_IDLE, S_PDOWN, S_MULT, S_DIVS, S_PUP, S_WAIT, S_CHECK, S_OUTEN,
    S_DONE, S_FAIL
  } seq_state_t;
endpackage

// File: rtl/pllseq_tick_timer.sv
module pllseq_tick_timer #(
  parameter int WAIT_TICKS = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic tick,
  output logic expire
);
  localparam int CW = $clog2(WAIT_TICKS + 1);
  localparam logic [CW-1:0] LAST = CW'(WAIT_TICKS - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (!run) begin
      cnt_en = (cnt_q != '0);
      cnt_d  = '0;
    end else if (tick) begin
      cnt_en = 1'b1;
      cnt_d  = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end
  end

  assign expire = run && tick && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // R5: the count stays inside the wait window
  p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);
endmodule

// File: rtl/pllseq_sample_ctr.sv
module pllseq_sample_ctr #(
  parameter int MAX_SAMPLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic last
);
  localparam int CW = $clog2(MAX_SAMPLES + 1);
  localparam logic [CW-1:0] LASTV = CW'(MAX_SAMPLES - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = clr | inc;
    cnt_d  = clr ? '0 : cnt_q + 1'b1;
  end

  assign last = (cnt_q == LASTV);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // R7: never counts past the sample limit
  p_sample_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    inc |-> !last);
endmodule

// File: rtl/pllseq_ctrl.sv
module pllseq_ctrl
  import pllseq_pkg::*;
#(
  parameter int WAIT_TICKS  = 10,
  parameter int MAX_SAMPLES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [DATA_W-1:0] cmd_mult,
  input  logic              tick,
  input  logic              lock_i,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              busy,
  output logic              done,
  output logic              fail
);
  seq_state_t        st_q, st_d;
  logic [DATA_W-1:0] mult_q;
  logic              mult_en;
  logic              wait_exp;
  logic              smp_last;
  logic              smp_clr, smp_inc;
  logic              accept;

  assign accept  = cmd_valid && (st_q == S_IDLE);
  assign mult_en = accept;

  pllseq_tick_timer #(.WAIT_TICKS(WAIT_TICKS)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(st_q == S_WAIT), .tick(tick),
    .expire(wait_exp)
  );

  assign smp_clr = accept;
  assign smp_inc = (st_q == S_CHECK) && !lock_i && !smp_last;

  pllseq_sample_ctr #(.MAX_SAMPLES(MAX_SAMPLES)) u_samples (
    .clk(clk), .rst_n(rst_n), .clr(smp_clr), .inc(smp_inc), .last(smp_last)
  );

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      S_IDLE:  if (cmd_valid) st_d = S_PDOWN;
      S_PDOWN: st_d = S_MULT;
      S_MULT:  st_d = S_DIVS;
      S_DIVS:  st_d = S_PUP;
      S_PUP:   st_d = S_WAIT;
      S_WAIT:  if (wait_exp) st_d = S_CHECK;
      S_CHECK: begin
        if (lock_i)        st_d = S_OUTEN;
        else if (smp_last) st_d = S_FAIL;
        else               st_d = S_WAIT;
      end
      S_OUTEN: st_d = S_DONE;
      S_DONE:  st_d = S_IDLE;
      S_FAIL:  st_d = S_IDLE;
      default: st_d = S_IDLE;
    endcase
  end

  always_comb begin
    wr_en   = 1'b0;
    wr_addr = A_CTRL;
    wr_data = '0;
    unique case (st_q)
      S_PDOWN: begin wr_en = 1'b1; wr_data[B_PWRDN] = 1'b1; end
      S_MULT:  begin wr_en = 1'b1; wr_addr = A_MULT; wr_data = mult_q; end
      S_DIVS:  begin wr_en = 1'b1; wr_addr = A_DIVS; wr_data = DIVS_UNITY; end
      S_PUP:   wr_en = 1'b1;
      S_OUTEN: begin wr_en = 1'b1; wr_data[B_OUTEN] = 1'b1; end
      default: ;
    endcase
  end

  assign cmd_ready = (st_q == S_IDLE);
  assign busy      = (st_q != S_IDLE);
  assign done      = (st_q == S_DONE);
  assign fail      = (st_q == S_FAIL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= S_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mult_q <= '0;
    else if (mult_en) mult_q <= cmd_mult;
  end

  // R2: an accepted command leads to a power-down write next cycle
  p_pdown_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> (wr_en && wr_addr == A_CTRL &&
                                  wr_data == 32'h1));
  // R3: the multiplier write carries the word taken at acceptance
  p_mult_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> ##1 (wr_addr == A_MULT &&
                                      wr_data == $past(cmd_mult, 2)));
  // R6: output enable is written only after lock was seen
  p_en_after_lock_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_CTRL && wr_data[B_OUTEN]) |-> $past(lock_i));
  // R8: no new command accepted while busy
  p_busy_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !cmd_ready);
  // R9: outcomes exclusive and single-cycle
  p_one_outcome_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && fail));
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: tb/pllseq_ctrl_test.sv
module pllseq_ctrl_test;
  localparam int WT = 4;
  localparam int MS = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [31:0] cmd_mult = '0;
  logic        tick = 1'b0;
  logic        lock_i = 1'b0;
  logic        wr_en;
  logic [1:0]  wr_addr;
  logic [31:0] wr_data;
  logic        busy, done, fail;

  int checks = 0;
  int fails  = 0;

  // lock model and monitor state
  int  lock_delay = -1;
  int  lock_cnt   = 0;
  bit  lock_arm   = 0;
  bit  tcount_on  = 0;
  int  tcount     = 0;
  int  n_writes   = 0;
  int  n_mult     = 0;
  int  n_en       = 0;
  int  n_done     = 0;
  logic [31:0] last_mult = '0;

  always #4 clk = ~clk;

  pllseq_ctrl #(.WAIT_TICKS(WT), .MAX_SAMPLES(MS)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_mult(cmd_mult), .tick(tick), .lock_i(lock_i), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .busy(busy), .done(done),
    .fail(fail)
  );

  initial begin
    int ph = 0;
    forever begin
      @(negedge clk);
      tick = (ph == 0);
      ph = (ph == 2) ? 0 : ph + 1;
    end
  end

  always @(negedge clk) begin
    if (wr_en) begin
      n_writes++;
      if (wr_addr == 2'd1) begin n_mult++; last_mult = wr_data; end
    end
    if ((wr_en && wr_addr == 2'd0 && wr_data == 32'h10) || fail)
      tcount_on = 0;
    else if (tcount_on && tick)
      tcount++;
    if (wr_en && wr_addr == 2'd0 && wr_data == 32'h10) n_en++;
    if (done) n_done++;
    if (wr_en && wr_addr == 2'd0 && wr_data == 32'h0) begin
      tcount_on = 1; tcount = 0; lock_arm = 1; lock_cnt = 0;
    end else if (wr_en && wr_addr == 2'd0 && wr_data[0]) begin
      lock_arm = 0;
    end else if (lock_arm) begin
      lock_cnt++;
    end
    lock_i = lock_arm && lock_delay >= 0 && lock_cnt >= lock_delay;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic chk_wr(input string req, input logic [1:0] a,
                        input logic [31:0] d);
    chk(wr_en === 1'b1 && wr_addr === a && wr_data === d, req, "write",
        {wr_en, wr_addr, wr_data}, {1'b1, a, d});
  endtask

  // run one sequence; returns 1 for done, 0 for fail
  task automatic run_seq(input logic [31:0] m, input int dly,
                         input bit poke_busy, output bit ok_done);
    int guard = 0;
    lock_delay = dly;
    n_writes = 0; n_mult = 0; n_en = 0; n_done = 0;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_mult = m;
    @(negedge clk);
    cmd_valid = poke_busy; cmd_mult = ~m;
    chk_wr("R2", 2'd0, 32'h1);
    chk(busy === 1'b1 && cmd_ready === 1'b0, "R8", "busy after accept",
        {busy, cmd_ready}, 2'b10);
    @(negedge clk); chk_wr("R3", 2'd1, m);
    @(negedge clk); chk_wr("R3", 2'd2, 32'h0030_2062);
    @(negedge clk); chk_wr("R4", 2'd0, 32'h0);
    ok_done = 0;
    while (!done && !fail && guard < 1000) begin
      @(negedge clk);
      guard++;
      if (busy && cmd_ready) chk(0, "R8", "ready while busy", 1, 0);
      if (wr_en && wr_addr == 2'd0 && wr_data == 32'h10) begin
        @(negedge clk);
        chk(done === 1'b1 && fail === 1'b0, "R6", "done after enable",
            {done, fail}, 2'b10);
      end
    end
    ok_done = done;
    chk(busy === 1'b1, "R8", "busy in outcome cycle", busy, 1);
    cmd_valid = 1'b0;
    @(negedge clk);
    chk(done === 1'b0 && fail === 1'b0 && cmd_ready === 1'b1, "R9",
        "pulse one cycle", {done, fail, cmd_ready}, 3'b001);
  endtask

  task automatic t_reset;
    chk(cmd_ready === 1'b1 && busy === 1'b0 && done === 1'b0 &&
        fail === 1'b0 && wr_en === 1'b0, "R1", "reset outputs",
        {cmd_ready, busy, done, fail, wr_en}, 5'b10000);
  endtask

  task automatic t_lock_first;
    bit ok;
    run_seq(32'h0001_2345, 1, 0, ok);
    chk(ok, "R6", "completes done", ok, 1);
    chk(tcount == WT, "R5", "ticks before first sample", tcount, WT);
    chk(n_en == 1 && n_writes == 5, "R6", "write count", n_writes, 5);
  endtask

  task automatic t_lock_third;
    bit ok;
    run_seq(32'h0000_4000, 30, 0, ok);
    chk(ok, "R6", "done on third sample", ok, 1);
    chk(tcount == 3 * WT, "R5", "ticks for three samples", tcount, 3 * WT);
  endtask

  task automatic t_no_lock;
    bit ok;
    run_seq(32'h0001_8003, -1, 0, ok);
    chk(!ok, "R7", "fails without lock", ok, 0);
    chk(tcount == MS * WT, "R7", "ticks over all samples", tcount, MS * WT);
    chk(n_en == 0 && n_writes == 4, "R7", "no enable write", n_writes, 4);
  endtask

  task automatic t_busy_ignore;
    bit ok;
    run_seq(32'h0000_0abc, 2, 1, ok);
    chk(ok && n_done == 1, "R8", "single completion", n_done, 1);
    chk(n_mult == 1 && last_mult == 32'h0000_0abc, "R8",
        "multiplier word unchanged", last_mult, 32'h0000_0abc);
    repeat (6) @(negedge clk);
    chk(n_writes == 5 && wr_en === 1'b0, "R8", "no extra sequence",
        n_writes, 5);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_lock_first();
    t_lock_third();
    t_no_lock();
    t_busy_ignore();
    t_lock_first();
    $display("End of test - %0d assertions evaluated, %0d failures",
             checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures",
             checks, fails);
    $finish;
  end
endmodule